// File: doc/BRIEF.md
# Edge-Triggered Manual Reset Timer

This block is a reset controller driven by a manual reset pin. A polarity strap selects the pin's active level. Only the transition into the active level is acted on. That transition starts a fixed timeout counted in system clock cycles, and the timeout holds the reset output asserted. When the count runs out, the reset output releases, even if the pin is still held active.

A second output, the memory-disable flag, blocks memory access while any reset cause is present: the timer is running, the power-on request is high, or the pin is held active. A pin held down longer than the timeout therefore keeps memory locked after the reset output has released. The power-on request is a digital input. It forces reset for as long as it is high and then starts the same timeout when it drops.

The reset output has the opposite polarity to the pin. The timeout length is a parameter, so simulation can use a short value in place of the long nominal period.

Top module: `mrst_timer`

## Requirements
- R1: With `pol_high_i`=0 the pin is active-low and a falling edge starts the timer. With `pol_high_i`=1 the pin is active-high and a rising edge starts it. An edge toward the inactive level never starts the timer.
- R2: The pin passes through a two-flop synchroniser. A pin change made between clock edges asserts reset after the third rising clock edge that follows it.
- R3: Once started, reset stays asserted for exactly `TIMEOUT_CYC` clock cycles and then releases, even if the pin is still at its active level.
- R4: Holding the pin at its active level neither restarts nor extends the count. After the release, reset stays inactive until a new active edge arrives.
- R5: An active edge that arrives while a count is running reloads the counter to `TIMEOUT_CYC`. Reset then releases `TIMEOUT_CYC` cycles after the reload.
- R6: `rst_cmp_o` uses the opposite polarity to the pin. With `pol_high_i`=0, a 1 means reset. With `pol_high_i`=1, a 0 means reset.
- R7: `mem_dis_o` is 1 whenever reset is asserted or the synchronised pin is active. It rises after the second clock edge following pin activation and falls after the second clock edge following pin release, provided the timer is idle.
- R8: While `por_req_i` is 1, reset and `mem_dis_o` are asserted without waiting for a clock. After `por_req_i` falls, reset releases on the `TIMEOUT_CYC`-th rising clock edge.
- R9: A low `rst_ni` asynchronously clears the counter and the synchroniser, so both outputs read inactive while `por_req_i` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset of the block's flops |
| pol_high_i | input | 1 | Polarity strap: 0 = pin active-low, 1 = pin active-high |
| mr_pin_i | input | 1 | Manual reset pin, asynchronous |
| por_req_i | input | 1 | Power-on reset request, active high |
| rst_cmp_o | output | 1 | Reset output, polarity opposite to the pin |
| mem_dis_o | output | 1 | Memory-disable flag, active high |

## Verification
The assertions assume the polarity strap is static while the timer is running. They also assume the power-on request changes only between clock edges. The stimulus therefore changes the strap only when the timer is idle and the pin sits at its inactive level, and it drives every input 2 ns after a rising edge. The reload check further assumes the pin stays inactive long enough for the synchroniser to see the release before the next press. The stimulus keeps every release at least two cycles long for that reason.

// File: rtl/mrt_pkg.sv
package mrt_pkg;
  typedef enum logic {
    PIN_ACT_LOW  = 1'b0,
    PIN_ACT_HIGH = 1'b1
  } pin_pol_e;

  function automatic logic norm_active(pin_pol_e pol, logic pin);
    return (pol == PIN_ACT_HIGH) ? pin : ~pin;
  endfunction
endpackage

// File: rtl/mrt_edge_sync.sv
module mrt_edge_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic act_i,
  output logic lvl_o,
  output logic rise_o
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) sync_q <= '0;
        else         sync_q <= act_i;
    end else begin : g_multi
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) sync_q <= '0;
        else         sync_q <= {sync_q[STAGES-2:0], act_i};
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= sync_q[STAGES-1];

  assign lvl_o  = sync_q[STAGES-1];
  assign rise_o = sync_q[STAGES-1] & ~prev_q;

  p_single_pulse_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |=> !rise_o);
endmodule

// File: rtl/mrt_timer.sv
module mrt_timer #(
  parameter int unsigned TIMEOUT_CYC = 20_000_000,
  localparam int unsigned CNT_W      = $clog2(TIMEOUT_CYC + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  output logic busy_o
);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(TIMEOUT_CYC);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)           cnt_q <= '0;
    else if (load_i)       cnt_q <= FULL;
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;

  assign busy_o = (cnt_q != '0);

  p_reload_full_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> cnt_q == FULL);
  p_count_down_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && cnt_q != '0) |=> cnt_q == $past(cnt_q) - 1'b1);
  p_idle_holds_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && cnt_q == '0) |=> cnt_q == '0);
endmodule

// File: rtl/mrst_timer.sv
module mrst_timer
  import mrt_pkg::*;
#(
  parameter int unsigned TIMEOUT_CYC = 20_000_000,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pol_high_i,
  input  logic mr_pin_i,
  input  logic por_req_i,
  output logic rst_cmp_o,
  output logic mem_dis_o
);
  pin_pol_e pol;
  logic     act_raw, act_lvl, act_edge, busy, rst_active;

  assign pol     = pin_pol_e'(pol_high_i);
  assign act_raw = norm_active(pol, mr_pin_i);

  mrt_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .act_i  (act_raw),
    .lvl_o  (act_lvl),
    .rise_o (act_edge)
  );

  // power-on request holds the counter full; countdown starts when it drops
  mrt_timer #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (act_edge | por_req_i),
    .busy_o (busy)
  );

  assign rst_active = busy | por_req_i;
  assign rst_cmp_o  = (pol == PIN_ACT_HIGH) ? ~rst_active : rst_active;
  assign mem_dis_o  = rst_active | act_lvl;

  p_por_forces_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    por_req_i |-> rst_active && mem_dis_o);
  p_edge_starts_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act_edge |=> rst_active);
  p_memdis_covers_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_active |-> mem_dis_o);
  p_held_blocks_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act_lvl |-> mem_dis_o);
endmodule

// File: tb/mrst_timer_tb.sv
`timescale 1ns/1ps
module mrst_timer_tb_top;
  localparam int unsigned T = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pol = 1'b0;
  logic pin = 1'b1;
  logic por = 1'b0;
  logic rst_cmp, mem_dis;
  int   checks = 0;
  int   fails  = 0;

  always #4 clk = ~clk;

  mrst_timer #(.TIMEOUT_CYC(T)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .pol_high_i(pol), .mr_pin_i(pin),
    .por_req_i(por), .rst_cmp_o(rst_cmp), .mem_dis_o(mem_dis)
  );

  // R6 decode of the reset output, from the bench's own view
  function automatic logic in_rst();
    return pol ? ~rst_cmp : rst_cmp;
  endfunction

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic t_reset();
    chk("R9 rst out", in_rst(), 1'b0);
    chk("R9 mem_dis", mem_dis, 1'b0);
  endtask

  task automatic t_fall_trigger();
    pin = 1'b0;
    step(1); chk("R2 not yet", in_rst(), 1'b0); chk("R7 mem 1 edge", mem_dis, 1'b0);
    step(1); chk("R7 mem after 2", mem_dis, 1'b1); chk("R2 still off", in_rst(), 1'b0);
    step(1); chk("R2 active at 3", in_rst(), 1'b1); chk("R1 falling trig", in_rst(), 1'b1);
    chk("R6 active-high out", rst_cmp, 1'b1);
    step(T - 1); chk("R3 last active", in_rst(), 1'b1);
    step(1); chk("R3 released held", in_rst(), 1'b0); chk("R7 held mem", mem_dis, 1'b1);
    step(5); chk("R4 level ignored", in_rst(), 1'b0); chk("R7 still held", mem_dis, 1'b1);
    pin = 1'b1;
    step(1); chk("R7 release lag", mem_dis, 1'b1);
    step(1); chk("R7 mem clear", mem_dis, 1'b0);
    step(3); chk("R1 rising ignored", in_rst(), 1'b0);
  endtask

  task automatic t_retrigger();
    pin = 1'b0; step(3); chk("R5 first load", in_rst(), 1'b1);
    step(3); pin = 1'b1; step(2);
    pin = 1'b0; step(3); chk("R5 reloaded", in_rst(), 1'b1);
    step(T - 1); chk("R5 full length", in_rst(), 1'b1);
    step(1); chk("R5 release", in_rst(), 1'b0);
    pin = 1'b1; step(3); chk("R7 idle clear", mem_dis, 1'b0);
  endtask

  task automatic t_active_high();
    pol = 1'b1; pin = 1'b0; step(3);
    chk("R6 idle high", rst_cmp, 1'b1);
    pin = 1'b1; step(3);
    chk("R1 rising trig", in_rst(), 1'b1); chk("R6 active low out", rst_cmp, 1'b0);
    step(T); chk("R3 release ah", rst_cmp, 1'b1);
    pin = 1'b0; step(4);
    chk("R1 falling ignored ah", rst_cmp, 1'b1); chk("R7 ah mem clear", mem_dis, 1'b0);
    pol = 1'b0; pin = 1'b1; step(3);
  endtask

  task automatic t_por();
    por = 1'b1; #1;
    chk("R8 immediate rst", in_rst(), 1'b1); chk("R8 immediate mem", mem_dis, 1'b1);
    step(10); chk("R8 held", in_rst(), 1'b1);
    por = 1'b0; step(T - 1); chk("R8 still counting", in_rst(), 1'b1);
    step(1); chk("R8 released", in_rst(), 1'b0); chk("R8 mem clear", mem_dis, 1'b0);
  endtask

  task automatic t_async_reset();
    pin = 1'b0; step(3); chk("R9 pre", in_rst(), 1'b1);
    rst_n = 1'b0; #1;
    chk("R9 async rst", in_rst(), 1'b0); chk("R9 async mem", mem_dis, 1'b0);
    pin = 1'b1; step(2); rst_n = 1'b1; step(3);
    chk("R9 after release", in_rst(), 1'b0);
  endtask

  initial begin
    step(2); t_reset();
    rst_n = 1'b1; step(3); t_reset();
    t_fall_trigger();
    t_retrigger();
    t_active_high();
    t_por();
    t_async_reset();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(8 * 200000);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule